// File: doc/BRIEF.md
# HDLC Frame Address Filter

This block decides, for every HDLC frame, whether the frame is addressed to this station. It sits after flag detection and bit de-stuffing and sees a byte stream with three strobes: one for the opening flag, one for each data byte, and one for the end of the frame. It collects the address bytes that follow the opening flag into a compare word. The first byte lands in the low half of that word and the second byte in the high half.

The compare word is checked against a set of programmable address registers. All of them share a single mask. A frame is accepted when any register matches under the mask. When the upper half of the mask is zero the block works in 8-bit address mode. In that mode it decides after the first address byte, and the upper register bits do not matter. The block reports each decision with a single-cycle strobe, an accept flag, and the index of the lowest-numbered register that hit. Registers that are not needed can be loaded with copies of a used address, so that they add no new matches.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After an opening flag, the first data byte fills bits 7:0 of the compare word and the second fills bits 15:8. With a nonzero upper mask byte, the decision strobe rises in the cycle after the second byte is presented, and not after the first.
- R2: Register n matches when (word & mask) equals (register n & mask) over all 16 bits. Register n occupies bits n*16+15 : n*16 of the address bus.
- R3: A frame is accepted when any register matches. The index output then gives the lowest-numbered matching register.
- R4: When mask bits 15:8 are all zero, the decision strobe rises in the cycle after the first byte. Register bits 15:8 are then ignored, and later bytes of the frame produce no further decision.
- R5: An end-of-frame strobe that arrives before the required address bytes gives a decision strobe with accept 0 and index 0. End-of-frame never yields accept.
- R6: An opening flag restarts address capture at any point, even in the middle of a frame. Strobe priority is flag, then end-of-frame, then byte. A byte that arrives together with a flag or end-of-frame strobe is ignored.
- R7: The address registers and the mask are sampled at the opening flag. A change to them during a frame affects only the next frame.
- R8: The decision strobe lasts one cycle. The accept and index outputs are 0 whenever the strobe is low. No decision comes from bytes seen before any opening flag, or from an end-of-frame strobe after the decision has already been made.
- R9: A synchronous reset clears all outputs and the capture state. After reset, bytes are ignored until the next opening flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| flag_i | input | 1 | Opening-flag strobe |
| byte_vld_i | input | 1 | Data-byte strobe |
| byte_i | input | 8 | De-stuffed data byte |
| eof_i | input | 1 | End-of-frame strobe |
| addr_i | input | 64 | Four 16-bit address registers, register n at bits n*16+15:n*16 |
| mask_i | input | 16 | Shared compare mask |
| dec_vld_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted, qualified by dec_vld_o |
| match_idx_o | output | 2 | Lowest matching register index |

## Verification
The table of frames tries the filter with several kinds of address. One is an exact 16-bit station address, which shows that the low byte comes first. One is a broadcast value in a register other than zero. The table also has an 8-bit address under mask 0x00FF with random upper register bits, a partial mask that hides a nibble, a byte-swapped address that must be rejected, and several registers that hit at once, which pins down the priority. Directed sequences cover the rest: frames that end too soon, a flag in the middle of a frame, a flag or end-of-frame strobe in the same cycle as a byte, register writes during a frame, bytes before any flag, and a reset during capture. Each one shows whether the block tracks frame boundaries and timing as well as the compare itself.

// File: rtl/hdlc_filt_pkg.sv
package hdlc_filt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for an opening flag
        ST_LO   = 2'd1,   // waiting for first address byte
        ST_HI   = 2'd2,   // waiting for second address byte
        ST_DONE = 2'd3    // decision made, ignore rest of frame
    } filt_st_e;

endpackage

// File: rtl/hdlc_addr_cmp.sv
module hdlc_addr_cmp #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] word_i,
    input  logic [AW-1:0] ref_i,
    input  logic [AW-1:0] mask_i,
    output logic          hit_o
);

    always_comb begin
        hit_o = ((word_i ^ ref_i) & mask_i) == '0;
    end

endmodule

// File: rtl/hdlc_addr_prio.sv
module hdlc_addr_prio #(
    parameter int N    = 4,
    parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hit_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        any_o = |hit_i;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (hit_i[k]) begin
                idx_o = IW'(k);
            end
        end
    end

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import hdlc_filt_pkg::*;
#(
    parameter int NUM_ADDR = 4,
    parameter int BYTE_W   = 8,
    localparam int AW      = 2 * BYTE_W,
    localparam int IDX_W   = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   flag_i,
    input  logic                   byte_vld_i,
    input  logic [BYTE_W-1:0]      byte_i,
    input  logic                   eof_i,
    input  logic [NUM_ADDR*AW-1:0] addr_i,
    input  logic [AW-1:0]          mask_i,
    output logic                   dec_vld_o,
    output logic                   accept_o,
    output logic [IDX_W-1:0]       match_idx_o
);

    typedef struct packed {
        filt_st_e                st;
        logic [BYTE_W-1:0]       lo;
        logic [NUM_ADDR*AW-1:0]  addr;
        logic [AW-1:0]           mask;
        logic                    dec_vld;
        logic                    accept;
        logic [IDX_W-1:0]        idx;
    } filt_state_t;

    localparam filt_state_t RST_STATE = '{
        st:      ST_IDLE,
        lo:      '0,
        addr:    '0,
        mask:    '0,
        dec_vld: 1'b0,
        accept:  1'b0,
        idx:     '0
    };

    filt_state_t r_q, r_d;

    logic [AW-1:0]       cmp_word;
    logic [NUM_ADDR-1:0] hit_vec;
    logic                any_hit;
    logic [IDX_W-1:0]    hit_idx;
    logic                short_mode;

    // Compare word: in the second-byte state the new byte is the high half,
    // otherwise the incoming byte is the low half with the upper half zero.
    always_comb begin
        if (r_q.st == ST_HI) begin
            cmp_word = {byte_i, r_q.lo};
        end else begin
            cmp_word = {{BYTE_W{1'b0}}, byte_i};
        end
        short_mode = (r_q.mask[AW-1:BYTE_W] == '0);
    end

    for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
        hdlc_addr_cmp #(
            .AW (AW)
        ) u_cmp (
            .word_i (cmp_word),
            .ref_i  (r_q.addr[g*AW +: AW]),
            .mask_i (r_q.mask),
            .hit_o  (hit_vec[g])
        );
    end

    hdlc_addr_prio #(
        .N  (NUM_ADDR),
        .IW (IDX_W)
    ) u_prio (
        .hit_i (hit_vec),
        .any_o (any_hit),
        .idx_o (hit_idx)
    );

    always_comb begin
        r_d         = r_q;
        r_d.dec_vld = 1'b0;
        r_d.accept  = 1'b0;
        r_d.idx     = '0;

        if (flag_i) begin
            r_d.st   = ST_LO;
            r_d.lo   = '0;
            r_d.addr = addr_i;
            r_d.mask = mask_i;
        end else if (eof_i) begin
            if ((r_q.st == ST_LO) || (r_q.st == ST_HI)) begin
                r_d.dec_vld = 1'b1;
            end
            r_d.st = ST_IDLE;
        end else if (byte_vld_i) begin
            unique case (r_q.st)
                ST_LO: begin
                    r_d.lo = byte_i;
                    if (short_mode) begin
                        r_d.dec_vld = 1'b1;
                        r_d.accept  = any_hit;
                        r_d.idx     = any_hit ? hit_idx : '0;
                        r_d.st      = ST_DONE;
                    end else begin
                        r_d.st = ST_HI;
                    end
                end
                ST_HI: begin
                    r_d.dec_vld = 1'b1;
                    r_d.accept  = any_hit;
                    r_d.idx     = any_hit ? hit_idx : '0;
                    r_d.st      = ST_DONE;
                end
                default: begin
                    r_d.st = r_q.st;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= RST_STATE;
        end else begin
            r_q <= r_d;
        end
    end

    assign dec_vld_o   = r_q.dec_vld;
    assign accept_o    = r_q.accept;
    assign match_idx_o = r_q.idx;

endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk #(
    parameter int NUM_ADDR = 4,
    parameter int IDX_W    = 2
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             flag_i,
    input logic             eof_i,
    input logic             dec_vld_o,
    input logic             accept_o,
    input logic [IDX_W-1:0] match_idx_o
);

    // R8: outputs qualified by the strobe
    a_r8_quiet_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !dec_vld_o |-> (!accept_o && match_idx_o == '0));

    // R8: strobe is a single cycle
    a_r8_single_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        dec_vld_o |=> !dec_vld_o);

    // R6: an opening flag never produces a decision
    a_r6_flag_no_decision: assert property (@(posedge clk_i) disable iff (rst_i)
        flag_i |=> !dec_vld_o);

    // R5: end of frame never accepts
    a_r5_eof_rejects: assert property (@(posedge clk_i) disable iff (rst_i)
        (eof_i && !flag_i) |=> !accept_o);

    // R3: index within register range
    a_r3_idx_range: assert property (@(posedge clk_i) disable iff (rst_i)
        accept_o |-> (int'(match_idx_o) < NUM_ADDR));

    // R9: nothing reported the cycle after reset
    a_r9_reset_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !dec_vld_o);

endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk #(
    .NUM_ADDR (NUM_ADDR),
    .IDX_W    (IDX_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .flag_i      (flag_i),
    .eof_i       (eof_i),
    .dec_vld_o   (dec_vld_o),
    .accept_o    (accept_o),
    .match_idx_o (match_idx_o)
);

// File: tb/hdlc_addr_filter_tb.sv
`timescale 1ns/1ps
module hdlc_addr_filter_tb;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        flag_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        eof_i = 1'b0;
    logic [63:0] addr_i = '0;
    logic [15:0] mask_i = '0;
    logic        dec_vld_o;
    logic        accept_o;
    logic [1:0]  match_idx_o;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    always #10 clk_i = ~clk_i;   // 50 MHz

    hdlc_addr_filter u_dut (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .flag_i      (flag_i),
        .byte_vld_i  (byte_vld_i),
        .byte_i      (byte_i),
        .eof_i       (eof_i),
        .addr_i      (addr_i),
        .mask_i      (mask_i),
        .dec_vld_o   (dec_vld_o),
        .accept_o    (accept_o),
        .match_idx_o (match_idx_o)
    );

    // mask, {a3,a2,a1,a0}, first byte, second byte, accept, index
    localparam int NV = 8;
    localparam logic [98:0] VECS [NV] = '{
        {16'hFFFF, 16'h3333, 16'h2222, 16'h1111, 16'hAA68, 8'h68, 8'hAA, 1'b1, 2'd0},
        {16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 16'h1234, 8'hFF, 8'hFF, 1'b1, 2'd1},
        {16'h00FF, 16'hC755, 16'h9955, 16'h0155, 16'h1255, 8'h55, 8'h00, 1'b1, 2'd0},
        {16'hFFFF, 16'h0004, 16'h0003, 16'h0002, 16'h0001, 8'h68, 8'hAA, 1'b0, 2'd0},
        {16'hFFFF, 16'hBEEF, 16'hBEEF, 16'hBEEF, 16'h1111, 8'hEF, 8'hBE, 1'b1, 2'd1},
        {16'hF0FF, 16'h5068, 16'h0000, 16'h0000, 16'h0000, 8'h68, 8'h5A, 1'b1, 2'd3},
        {16'hFFFF, 16'hAA68, 16'hAA68, 16'hAA68, 16'hAA68, 8'hAA, 8'h68, 1'b0, 2'd0},
        {16'h00FF, 16'h9942, 16'h0043, 16'h0043, 16'h0043, 8'h42, 8'h00, 1'b1, 2'd3}
    };

    // Present one cycle of strobes from a negedge, return at next negedge
    task automatic cyc(input logic f, input logic v, input logic [7:0] b, input logic e);
        flag_i = f; byte_vld_i = v; byte_i = b; eof_i = e;
        @(negedge clk_i);
        flag_i = 1'b0; byte_vld_i = 1'b0; byte_i = '0; eof_i = 1'b0;
    endtask

    task automatic chk(input string tag, input logic ev, input logic ea, input logic [1:0] ei);
        checks++;
        if (dec_vld_o !== ev || accept_o !== ea || match_idx_o !== ei) begin
            failures++;
            $display("FAIL %s: got vld=%0b acc=%0b idx=%0d exp vld=%0b acc=%0b idx=%0d",
                     tag, dec_vld_o, accept_o, match_idx_o, ev, ea, ei);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk_i) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        chk("R9 reset outputs", 0, 0, 0);
        rst_i = 1'b0;

        // R8: bytes before any opening flag are ignored
        addr_i = {4{16'h0011}}; mask_i = 16'h00FF;
        cyc(0, 1, 8'h11, 0); chk("R8 byte before flag", 0, 0, 0);
        cyc(0, 1, 8'h11, 0); chk("R8 byte before flag 2", 0, 0, 0);
        cyc(0, 0, 8'h00, 1); chk("R8 eof before flag", 0, 0, 0);

        // Table: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            logic [15:0] m;
            logic        eight;
            m      = VECS[i][98:83];
            addr_i = VECS[i][82:19];
            mask_i = m;
            eight  = (m[15:8] == 8'h00);
            cyc(1, 0, 8'h00, 0); chk("R6 flag no decision", 0, 0, 0);
            cyc(0, 1, VECS[i][18:11], 0);
            if (eight) begin
                chk($sformatf("R4 vec%0d 8-bit decision", i), 1, VECS[i][2], VECS[i][1:0]);
                cyc(0, 1, VECS[i][10:3], 0);
                chk($sformatf("R4 vec%0d later byte ignored", i), 0, 0, 0);
            end else begin
                chk($sformatf("R1 vec%0d no decision after first byte", i), 0, 0, 0);
                cyc(0, 1, VECS[i][10:3], 0);
                chk($sformatf("R2 R3 vec%0d 16-bit decision", i), 1, VECS[i][2], VECS[i][1:0]);
                cyc(0, 1, 8'h44, 0);
                chk($sformatf("R8 vec%0d control byte ignored", i), 0, 0, 0);
            end
            cyc(0, 0, 8'h00, 1);
            chk($sformatf("R8 vec%0d eof after decision", i), 0, 0, 0);
        end

        // R5: short frames
        addr_i = {4{16'hAA68}}; mask_i = 16'hFFFF;
        cyc(1, 0, 0, 0); cyc(0, 1, 8'h68, 0); cyc(0, 0, 0, 1);
        chk("R5 eof after one byte", 1, 0, 0);
        cyc(1, 0, 0, 0); cyc(0, 0, 0, 1);
        chk("R5 eof right after flag", 1, 0, 0);
        mask_i = 16'h00FF;
        cyc(1, 0, 0, 0); cyc(0, 0, 0, 1);
        chk("R5 eof right after flag 8-bit", 1, 0, 0);

        // R6: eof with byte in same cycle: byte ignored, reject
        mask_i = 16'hFFFF;
        cyc(1, 0, 0, 0); cyc(0, 1, 8'h68, 0); cyc(0, 1, 8'hAA, 1);
        chk("R6 eof beats byte", 1, 0, 0);

        // R6: restart in the middle of a frame
        cyc(1, 0, 0, 0); cyc(0, 1, 8'h11, 0);
        cyc(1, 0, 0, 0); chk("R6 mid-frame flag", 0, 0, 0);
        cyc(0, 1, 8'h68, 0); cyc(0, 1, 8'hAA, 0);
        chk("R6 restart accept", 1, 1, 0);

        // R6: flag with byte in same cycle: byte ignored
        cyc(1, 1, 8'hAA, 0); cyc(0, 1, 8'h68, 0);
        chk("R6 flag beats byte", 0, 0, 0);
        cyc(0, 1, 8'hAA, 0);
        chk("R6 flag beats byte decision", 1, 1, 0);

        // R7: registers sampled at flag
        addr_i = {16'h0, 16'h0, 16'h0, 16'hAA68}; mask_i = 16'hFFFF;
        cyc(1, 0, 0, 0);
        addr_i = '0; mask_i = 16'h00FF;
        cyc(0, 1, 8'h68, 0);
        chk("R7 mask change mid-frame ignored", 0, 0, 0);
        cyc(0, 1, 8'hAA, 0);
        chk("R7 addr change mid-frame ignored", 1, 1, 0);
        mask_i = 16'hFFFF;
        cyc(1, 0, 0, 0); cyc(0, 1, 8'h68, 0); cyc(0, 1, 8'hAA, 0);
        chk("R7 new regs next frame", 1, 0, 0);

        // R9: reset during capture
        addr_i = {4{16'hAA68}};
        cyc(1, 0, 0, 0); cyc(0, 1, 8'h68, 0);
        rst_i = 1'b1; cyc(0, 0, 0, 0); rst_i = 1'b0;
        chk("R9 reset mid-frame", 0, 0, 0);
        cyc(0, 1, 8'hAA, 0); chk("R9 byte after reset ignored", 0, 0, 0);
        cyc(0, 0, 0, 1); chk("R9 eof after reset ignored", 0, 0, 0);

        finish_run();
    end

endmodule